// File: doc/BRIEF.md
# Flag-Setting 16-bit Arithmetic and Logic Unit

This unit does the data work of a small 16-bit processor core. In a single cycle it combines a first operand, A, with a second operand. The second operand is either register B or an 8-bit constant. The unit presents the combinational result together with a write-enable for the destination register. On the next clock edge it stores carry, overflow, negative and zero into a 4-bit status register. The stored carry feeds back into the carry-chained add and subtract and into the rotates through carry. Arithmetic wider than 16 bits is built by issuing the low word with a plain add, then each higher word with the carry-chained add.

The operation set covers:
- add and subtract, with and without carry;
- XOR, OR and AND, each in a plain form and in a form that inverts the second operand;
- one-bit shifts and rotates through carry;
- a barrel rotate;
- bitwise invert and byte sign extension;
- six compare and test operations that change only the flags.

A separate load path writes the status register from a general register value, and the status output is the read path back. Register-file access and instruction decode are the job of the surrounding core.

Top module: `flag_alu`

## Requirements
- R1: `op` codes are 0–7 for the immediate forms (add, sub, xor, xnor, or, orn, and, andn), 8–11 for ADD, SUB, ADDC, SUBC, 12–17 for XOR, XNOR, OR, ORN, AND, ANDN, 18–23 for SHL, SHR, ROLC, RORC, ASHL, ASHR, 24 for ROTI, 25 for ROT, 26 for INV, 27 for BSE, and 28–33 for CMP, CMN, TST, TEQ, TCM, TIB. An immediate form uses `imm8`, zero-extended, in place of B and returns its result with `wr_en` high.
- R2: ADD gives A+B. SUB gives A+~B+1. ADDC gives A+B+C. SUBC gives A+~B+C. Carry is the carry out, so on a subtract carry set means no borrow. Overflow is the signed overflow of the sum.
- R3: The logic operations apply bitwise NOT to the second operand in their inverted forms. Every logic operation clears overflow and leaves carry unchanged.
- R4: The one-bit operations act on B. SHL and ASHL shift left and fill with 0. SHR fills bit 15 with 0. ASHR keeps bit 15. ROLC and RORC fill with the stored carry. In each case carry takes the bit that was shifted out and overflow is cleared.
- R5: ROTI rotates A left by `imm8[3:0]` and ROT rotates A left by `opb[3:0]`. An amount of 0, or of 16, returns A unchanged and keeps carry. Any other amount sets carry to result bit 0. Overflow is cleared.
- R6: INV returns ~B. BSE returns B with bit 7 copied into bits 15..8. Both clear overflow and keep carry.
- R7: CMP (subtract), CMN (add), TST (AND), TEQ (XOR), TCM (XNOR) and TIB (AND with inverted B) update the flags as their base operation would, and never raise `wr_en`.
- R8: For every flag-updating operation, negative is result bit 15 and zero is set exactly when the result is 0.
- R9: `status` bit order is {C, V, N, Z}, with C in bit 3 and Z in bit 0. When `sr_we` is high, the status register loads `sr_din` on the edge, and this takes priority over an operation in the same cycle.
- R10: With `op_valid` low, or with an unused code (34–63), `wr_en` stays low and the status register holds its value.
- R11: Synchronous reset clears the status register to 0.
- R12: `result` and `wr_en` are combinational in the current inputs and the stored carry. The flags appear on `status` after the clock edge that ends the operation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_valid | input | 1 | An operation is issued this cycle |
| op | input | 6 | Operation code |
| opa | input | 16 | Operand A |
| opb | input | 16 | Operand B |
| imm8 | input | 8 | Immediate constant or rotate amount |
| sr_we | input | 1 | Load the status register |
| sr_din | input | 4 | Value for the status register, {C,V,N,Z} |
| result | output | 16 | Operation result |
| wr_en | output | 1 | Destination write-enable |
| status | output | 4 | Stored flags, {C,V,N,Z} |

## Verification
The carry flag is the only state that feeds back into the datapath. A wrong stored carry therefore shows up in the very next ADDC, SUBC, ROLC or RORC result, in the same cycle that operation is issued. It shows up nowhere else. A fault in the flag logic appears on `status` one edge after the operation. For this reason each vector first loads a known carry, then checks the result before the edge and the flags after it. A faulty write-enable decode is visible at once on `wr_en`, and the compare and test codes and the unused codes are aimed at exactly that.

// File: rtl/flag_alu_pkg.sv
package flag_alu_pkg;

  typedef enum logic [5:0] {
    OP_ADDI = 6'd0, OP_SUBI, OP_XORI, OP_XNORI, OP_ORI, OP_ORNI, OP_ANDI, OP_ANDNI,
    OP_ADD  = 6'd8, OP_SUB, OP_ADDC, OP_SUBC,
    OP_XOR  = 6'd12, OP_XNOR, OP_OR, OP_ORN, OP_AND, OP_ANDN,
    OP_SHL  = 6'd18, OP_SHR, OP_ROLC, OP_RORC, OP_ASHL, OP_ASHR,
    OP_ROTI = 6'd24, OP_ROT,
    OP_INV  = 6'd26, OP_BSE,
    OP_CMP  = 6'd28, OP_CMN, OP_TST, OP_TEQ, OP_TCM, OP_TIB
  } alu_op_e;

  typedef enum logic [2:0] {
    K_NONE, K_ARITH, K_LOGIC, K_SHIFT, K_INV, K_BSE
  } alu_kind_e;

  typedef enum logic [1:0] { LF_XOR, LF_OR, LF_AND } logic_fn_e;

  typedef enum logic [2:0] {
    SK_SHL, SK_SHR, SK_ROLC, SK_RORC, SK_ASHR, SK_ROT
  } shift_kind_e;

  localparam int FLAG_C = 3;
  localparam int FLAG_V = 2;
  localparam int FLAG_N = 1;
  localparam int FLAG_Z = 0;

endpackage

// File: rtl/fa_addsub.sv
module fa_addsub #(
  parameter int W = 16
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         sub,
  input  logic         use_carry,
  input  logic         cin,
  output logic [W-1:0] sum,
  output logic         cout,
  output logic         ovf
);
  logic [W-1:0] b_eff;
  logic         c0;
  logic [W:0]   full;

  always_comb begin
    b_eff = sub ? ~b : b;
    c0    = use_carry ? cin : sub;
    full  = {1'b0, a} + {1'b0, b_eff} + {{W{1'b0}}, c0};
    sum   = full[W-1:0];
    cout  = full[W];
    ovf   = (a[W-1] == b_eff[W-1]) && (sum[W-1] != a[W-1]);
  end
endmodule

// File: rtl/fa_logic.sv
module fa_logic
  import flag_alu_pkg::*;
#(
  parameter int W = 16
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic_fn_e    fn,
  input  logic         inv_b,
  output logic [W-1:0] y
);
  logic [W-1:0] b_eff;

  always_comb begin
    b_eff = inv_b ? ~b : b;
    unique case (fn)
      LF_XOR:  y = a ^ b_eff;
      LF_OR:   y = a | b_eff;
      default: y = a & b_eff;
    endcase
  end
endmodule

// File: rtl/fa_shift.sv
module fa_shift
  import flag_alu_pkg::*;
#(
  parameter int W    = 16,
  parameter int SH_W = $clog2(W)
) (
  input  logic [W-1:0]    one_src,
  input  logic [W-1:0]    rot_src,
  input  logic [SH_W-1:0] amt,
  input  logic            cin,
  input  shift_kind_e     kind,
  output logic [W-1:0]    y,
  output logic            cout,
  output logic            cvalid
);
  logic [2*W-1:0] twice;

  always_comb begin
    twice  = {rot_src, rot_src} << amt;
    cvalid = 1'b1;
    unique case (kind)
      SK_SHL:  begin y = {one_src[W-2:0], 1'b0};          cout = one_src[W-1]; end
      SK_SHR:  begin y = {1'b0, one_src[W-1:1]};          cout = one_src[0];   end
      SK_ROLC: begin y = {one_src[W-2:0], cin};           cout = one_src[W-1]; end
      SK_RORC: begin y = {cin, one_src[W-1:1]};           cout = one_src[0];   end
      SK_ASHR: begin y = {one_src[W-1], one_src[W-1:1]};  cout = one_src[0];   end
      default: begin
        y      = twice[2*W-1:W];
        cout   = y[0];
        cvalid = (amt != '0);
      end
    endcase
  end
endmodule

// File: rtl/flag_alu.sv
module flag_alu
  import flag_alu_pkg::*;
#(
  parameter int W     = 16,
  parameter int IMM_W = 8,
  parameter int FW    = 4,
  parameter int OP_W  = 6
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             op_valid,
  input  logic [OP_W-1:0]  op,
  input  logic [W-1:0]     opa,
  input  logic [W-1:0]     opb,
  input  logic [IMM_W-1:0] imm8,
  input  logic             sr_we,
  input  logic [FW-1:0]    sr_din,
  output logic [W-1:0]     result,
  output logic             wr_en,
  output logic [FW-1:0]    status
);
  localparam int SH_W = $clog2(W);
  localparam int HALF = W / 2;

  alu_kind_e   kind;
  logic        sub, use_c, inv_b, use_imm, rot_imm, wr;
  logic_fn_e   lfn;
  shift_kind_e skind;

  always_comb begin
    kind = K_NONE; sub = 1'b0; use_c = 1'b0; inv_b = 1'b0;
    use_imm = 1'b0; rot_imm = 1'b0; wr = 1'b1;
    lfn = LF_AND; skind = SK_ROT;
    case (op)
      OP_ADDI:  begin kind = K_ARITH; use_imm = 1'b1; end
      OP_SUBI:  begin kind = K_ARITH; use_imm = 1'b1; sub = 1'b1; end
      OP_XORI:  begin kind = K_LOGIC; use_imm = 1'b1; lfn = LF_XOR; end
      OP_XNORI: begin kind = K_LOGIC; use_imm = 1'b1; lfn = LF_XOR; inv_b = 1'b1; end
      OP_ORI:   begin kind = K_LOGIC; use_imm = 1'b1; lfn = LF_OR; end
      OP_ORNI:  begin kind = K_LOGIC; use_imm = 1'b1; lfn = LF_OR; inv_b = 1'b1; end
      OP_ANDI:  begin kind = K_LOGIC; use_imm = 1'b1; end
      OP_ANDNI: begin kind = K_LOGIC; use_imm = 1'b1; inv_b = 1'b1; end
      OP_ADD:   kind = K_ARITH;
      OP_SUB:   begin kind = K_ARITH; sub = 1'b1; end
      OP_ADDC:  begin kind = K_ARITH; use_c = 1'b1; end
      OP_SUBC:  begin kind = K_ARITH; use_c = 1'b1; sub = 1'b1; end
      OP_XOR:   begin kind = K_LOGIC; lfn = LF_XOR; end
      OP_XNOR:  begin kind = K_LOGIC; lfn = LF_XOR; inv_b = 1'b1; end
      OP_OR:    begin kind = K_LOGIC; lfn = LF_OR; end
      OP_ORN:   begin kind = K_LOGIC; lfn = LF_OR; inv_b = 1'b1; end
      OP_AND:   kind = K_LOGIC;
      OP_ANDN:  begin kind = K_LOGIC; inv_b = 1'b1; end
      OP_SHL, OP_ASHL: begin kind = K_SHIFT; skind = SK_SHL; end
      OP_SHR:   begin kind = K_SHIFT; skind = SK_SHR; end
      OP_ROLC:  begin kind = K_SHIFT; skind = SK_ROLC; end
      OP_RORC:  begin kind = K_SHIFT; skind = SK_RORC; end
      OP_ASHR:  begin kind = K_SHIFT; skind = SK_ASHR; end
      OP_ROTI:  begin kind = K_SHIFT; rot_imm = 1'b1; end
      OP_ROT:   kind = K_SHIFT;
      OP_INV:   kind = K_INV;
      OP_BSE:   kind = K_BSE;
      OP_CMP:   begin kind = K_ARITH; sub = 1'b1; wr = 1'b0; end
      OP_CMN:   begin kind = K_ARITH; wr = 1'b0; end
      OP_TST:   begin kind = K_LOGIC; wr = 1'b0; end
      OP_TEQ:   begin kind = K_LOGIC; lfn = LF_XOR; wr = 1'b0; end
      OP_TCM:   begin kind = K_LOGIC; lfn = LF_XOR; inv_b = 1'b1; wr = 1'b0; end
      OP_TIB:   begin kind = K_LOGIC; inv_b = 1'b1; wr = 1'b0; end
      default:  wr = 1'b0;
    endcase
  end

  logic [W-1:0]    b_sel;
  logic [SH_W-1:0] amt;
  logic            c_cur;

  assign b_sel = use_imm ? {{(W-IMM_W){1'b0}}, imm8} : opb;
  assign amt   = rot_imm ? imm8[SH_W-1:0] : opb[SH_W-1:0];
  assign c_cur = status[FLAG_C];

  logic [W-1:0] ar_y, lg_y, sh_y;
  logic         ar_c, ar_v, sh_c, sh_cv;

  fa_addsub #(.W(W)) u_addsub (
    .a(opa), .b(b_sel), .sub(sub), .use_carry(use_c), .cin(c_cur),
    .sum(ar_y), .cout(ar_c), .ovf(ar_v)
  );

  fa_logic #(.W(W)) u_logic (
    .a(opa), .b(b_sel), .fn(lfn), .inv_b(inv_b), .y(lg_y)
  );

  fa_shift #(.W(W), .SH_W(SH_W)) u_shift (
    .one_src(opb), .rot_src(opa), .amt(amt), .cin(c_cur), .kind(skind),
    .y(sh_y), .cout(sh_c), .cvalid(sh_cv)
  );

  logic c_nxt, v_nxt;

  always_comb begin
    c_nxt = c_cur;
    v_nxt = 1'b0;
    case (kind)
      K_ARITH: begin result = ar_y; c_nxt = ar_c; v_nxt = ar_v; end
      K_LOGIC: result = lg_y;
      K_SHIFT: begin result = sh_y; if (sh_cv) c_nxt = sh_c; end
      K_INV:   result = ~opb;
      K_BSE:   result = {{HALF{opb[HALF-1]}}, opb[HALF-1:0]};
      default: result = '0;
    endcase
  end

  logic known;
  assign known = (kind != K_NONE);
  assign wr_en = op_valid && known && wr;

  always_ff @(posedge clk) begin
    if (rst)                   status <= '0;
    else if (sr_we)            status <= sr_din;
    else if (op_valid && known) status <= {c_nxt, v_nxt, result[W-1], (result == '0)};
  end

  // R11: reset clears the flags
  a_r11_reset_clear: assert property (@(posedge clk) rst |=> status == '0);
  // R9: status load path wins
  a_r9_status_load: assert property (@(posedge clk) disable iff (rst)
    sr_we |=> status == $past(sr_din));
  // R10: no operation, no flag change
  a_r10_flags_hold: assert property (@(posedge clk) disable iff (rst)
    (!sr_we && !(op_valid && known)) |=> $stable(status));
  // R3: logic ops clear overflow
  a_r3_no_overflow: assert property (@(posedge clk) disable iff (rst)
    (!sr_we && op_valid && kind == K_LOGIC) |=> !status[FLAG_V]);
  // R8: zero and negative follow the result
  a_r8_zero_neg: assert property (@(posedge clk) disable iff (rst)
    (!sr_we && op_valid && known) |=>
      (status[FLAG_Z] == ($past(result) == '0)) && (status[FLAG_N] == $past(result[W-1])));
  // R7: compare and test never write
  a_r7_no_write: assert property (@(posedge clk) disable iff (rst)
    (op >= OP_CMP && op <= OP_TIB) |-> !wr_en);
endmodule

// File: tb/flag_alu_test.sv
module flag_alu_test;
  import flag_alu_pkg::*;

  logic        clk = 1'b0;
  logic        rst;
  logic        op_valid;
  logic [5:0]  op;
  logic [15:0] opa, opb;
  logic [7:0]  imm8;
  logic        sr_we;
  logic [3:0]  sr_din;
  logic [15:0] result;
  logic        wr_en;
  logic [3:0]  status;

  int checks = 0;
  int fails  = 0;

  always #5 clk = ~clk;

  flag_alu uut (
    .clk(clk), .rst(rst), .op_valid(op_valid), .op(op), .opa(opa), .opb(opb),
    .imm8(imm8), .sr_we(sr_we), .sr_din(sr_din),
    .result(result), .wr_en(wr_en), .status(status)
  );

  // {op, a, b, imm, cin, exp_result, exp_we, exp_flags{C,V,N,Z}}
  localparam int NV = 27;
  localparam logic [67:0] VEC [NV] = '{
    {OP_ADD,  16'h7FFF, 16'h0001, 8'h00, 1'b0, 16'h8000, 1'b1, 4'h6}, // R2 R8
    {OP_ADD,  16'hFFFF, 16'h0001, 8'h00, 1'b0, 16'h0000, 1'b1, 4'h9}, // R2
    {OP_SUB,  16'h0005, 16'h0005, 8'h00, 1'b0, 16'h0000, 1'b1, 4'h9}, // R2
    {OP_SUB,  16'h0003, 16'h0005, 8'h00, 1'b0, 16'hFFFE, 1'b1, 4'h2}, // R2
    {OP_SUB,  16'h8000, 16'h0001, 8'h00, 1'b0, 16'h7FFF, 1'b1, 4'hC}, // R2
    {OP_ADDC, 16'h0001, 16'h0001, 8'h00, 1'b1, 16'h0003, 1'b1, 4'h0}, // R2
    {OP_SUBC, 16'h0005, 16'h0003, 8'h00, 1'b0, 16'h0001, 1'b1, 4'h8}, // R2
    {OP_ADDI, 16'h00F0, 16'hFFFF, 8'h20, 1'b0, 16'h0110, 1'b1, 4'h0}, // R1
    {OP_ANDNI,16'h00FF, 16'h0000, 8'h0F, 1'b1, 16'h00F0, 1'b1, 4'h8}, // R1 R3
    {OP_XNOR, 16'h00FF, 16'h0F0F, 8'h00, 1'b0, 16'hF00F, 1'b1, 4'h2}, // R3
    {OP_ORN,  16'h0000, 16'hFFFF, 8'h00, 1'b0, 16'h0000, 1'b1, 4'h1}, // R3
    {OP_SHL,  16'h1234, 16'h8001, 8'h00, 1'b0, 16'h0002, 1'b1, 4'h8}, // R4
    {OP_RORC, 16'h0000, 16'h0002, 8'h00, 1'b1, 16'h8001, 1'b1, 4'h2}, // R4
    {OP_ASHR, 16'h0000, 16'h8003, 8'h00, 1'b0, 16'hC001, 1'b1, 4'hA}, // R4
    {OP_ROLC, 16'h0000, 16'h8000, 8'h00, 1'b0, 16'h0000, 1'b1, 4'h9}, // R4
    {OP_ROTI, 16'h1234, 16'h0000, 8'h04, 1'b0, 16'h2341, 1'b1, 4'h8}, // R5
    {OP_ROT,  16'h8001, 16'h0010, 8'h00, 1'b0, 16'h8001, 1'b1, 4'h2}, // R5
    {OP_ROT,  16'h8001, 16'h0001, 8'h00, 1'b0, 16'h0003, 1'b1, 4'h8}, // R5
    {OP_INV,  16'h0000, 16'h00FF, 8'h00, 1'b0, 16'hFF00, 1'b1, 4'h2}, // R6
    {OP_BSE,  16'h0000, 16'h1280, 8'h00, 1'b0, 16'hFF80, 1'b1, 4'h2}, // R6
    {OP_BSE,  16'h0000, 16'hAB7F, 8'h00, 1'b0, 16'h007F, 1'b1, 4'h0}, // R6
    {OP_CMP,  16'h0003, 16'h0003, 8'h00, 1'b0, 16'h0000, 1'b0, 4'h9}, // R7
    {OP_TST,  16'hF0F0, 16'h0F0F, 8'h00, 1'b1, 16'h0000, 1'b0, 4'h9}, // R7
    {OP_CMN,  16'h7FFF, 16'h0001, 8'h00, 1'b0, 16'h8000, 1'b0, 4'h6}, // R7
    {OP_TIB,  16'h00FF, 16'h000F, 8'h00, 1'b0, 16'h00F0, 1'b0, 4'h0}, // R7
    {OP_SHR,  16'h0000, 16'h0001, 8'h00, 1'b0, 16'h0000, 1'b1, 4'h9}, // R4 R8
    {OP_XORI, 16'h00FF, 16'h1234, 8'hFF, 1'b0, 16'h0000, 1'b1, 4'h1}  // R1 R8
  };

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic idle();
    op_valid = 1'b0; sr_we = 1'b0; op = 6'd0;
    opa = '0; opb = '0; imm8 = '0; sr_din = '0;
  endtask

  task automatic load_status(input logic [3:0] v);
    @(negedge clk);
    idle(); sr_we = 1'b1; sr_din = v;
    @(negedge clk);
    sr_we = 1'b0;
  endtask

  task automatic run_vec(input int i);
    logic [67:0] v;
    v = VEC[i];
    load_status({v[21], 3'b000});
    op_valid = 1'b1; op = v[67:62]; opa = v[61:46]; opb = v[45:30]; imm8 = v[29:22];
    #1;
    check($sformatf("R12 result vec %0d", i), result, v[20:5]);
    check($sformatf("R1/R7 wr_en vec %0d", i), {15'b0, wr_en}, {15'b0, v[4]});
    @(negedge clk);
    idle();
    #1;
    check($sformatf("R8 flags vec %0d", i), {12'b0, status}, {12'b0, v[3:0]});
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("%0d/%0d checks passed", checks + 1 - fails, checks + 1);
    $finish;
  end

  initial begin
    idle();
    rst = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    #1;
    check("R11 status after reset", {12'b0, status}, 16'h0);
    check("R12 wr_en idle after reset", {15'b0, wr_en}, 16'h0);

    for (int i = 0; i < NV; i++) run_vec(i);

    // R10: op_valid low - no write, flags held
    load_status(4'h5);
    op_valid = 1'b0; op = OP_ADD; opa = 16'hFFFF; opb = 16'h0001;
    #1;
    check("R10 no wr_en when op_valid low", {15'b0, wr_en}, 16'h0);
    @(negedge clk);
    #1;
    check("R10 flags held when op_valid low", {12'b0, status}, 16'h5);

    // R10: unused code
    op_valid = 1'b1; op = 6'd40; opa = 16'h0000; opb = 16'h0000;
    #1;
    check("R10 unused code no wr_en", {15'b0, wr_en}, 16'h0);
    @(negedge clk);
    idle();
    #1;
    check("R10 unused code flags held", {12'b0, status}, 16'h5);

    // R9: load wins over a concurrent operation
    sr_we = 1'b1; sr_din = 4'hA; op_valid = 1'b1; op = OP_ADD; opa = 16'h0; opb = 16'h0;
    @(negedge clk);
    idle();
    #1;
    check("R9 status load priority", {12'b0, status}, 16'hA);

    // R2: two-word add chain 0x0001_FFFF + 0x0000_0001 = 0x0002_0000
    load_status(4'h0);
    op_valid = 1'b1; op = OP_ADD; opa = 16'hFFFF; opb = 16'h0001;
    @(negedge clk);
    op = OP_ADDC; opa = 16'h0001; opb = 16'h0000;
    #1;
    check("R2 chained high word", result, 16'h0002);
    @(negedge clk);
    idle();

    // R11: reset mid-run clears flags
    load_status(4'hF);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    #1;
    check("R11 reset clears loaded flags", {12'b0, status}, 16'h0);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule